// File: doc/BRIEF.md
# Write-to-Set Command Status Register

This block is a single 32-bit command and status word for a host controller. It sits on a simple synchronous register bus made of an address hit, a write enable, write data and read data. Software posts commands by writing ones. A write can only set bits and never clears them, so several commands can be posted in separate writes without a read-modify-write sequence and without losing commands already pending. When the controller has acted on a command, it clears that bit with a per-bit hardware clear strobe.

The same word holds a 2-bit scheduling-overrun count in bits 17:16. Hardware advances the count each time the periodic work of a frame has not finished by end of frame. The same event sets a sticky overrun flag, which is a separate output for an interrupt controller. That flag stays set until a dedicated one-cycle clear strobe removes it. The parameter `CMD_MASK` selects which bit positions hold commands. A build option decides who wins when a software set and a hardware clear hit the same bit in the same cycle.

Top module: `cmd_status_reg`

## Requirements
- R1: After a synchronous reset, every bit of the register, the command output `cmd_q` and `ovr_flag` are 0.
- R2: A write with `reg_hit` and `reg_wr` both high sets every command bit (default `CMD_MASK` = bits 4:0) whose `reg_wdata` bit is 1. Command bits written as 0 keep their value, so successive writes accumulate.
- R3: `reg_wdata` has no effect unless `reg_hit` and `reg_wr` are both high in the same cycle.
- R4: A high bit of `hw_clr` clears the matching command bit on the next clock edge. `hw_clr` bits outside the command mask have no effect.
- R5: When a software set and a hardware clear hit the same command bit in one cycle, the set wins with `CLR_WINS` = 0 and the clear wins with `CLR_WINS` = 1.
- R6: Each cycle with `eof_overrun` high adds one to the count read at bits 17:16, and the count wraps from 3 to 0.
- R7: Software writes to bits 17:16 leave the overrun count unchanged.
- R8: `eof_overrun` sets `ovr_flag`. The flag stays set until a cycle with `ovr_flag_clr` high and `eof_overrun` low. When both are high in the same cycle, the flag is set.
- R9: Bits outside the command mask and outside 17:16 always read 0 and ignore writes.
- R10: `reg_rdata` shows the current register value in the same cycle that `reg_hit` is high, and it is 0 while `reg_hit` is low.
- R11: `cmd_q` always equals the command bits of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_hit | input | 1 | Register bus addresses this word |
| reg_wr | input | 1 | Bus cycle is a write |
| reg_wdata | input | 32 | Write data; ones set command bits |
| reg_rdata | output | 32 | Read data, 0 when not addressed |
| hw_clr | input | 32 | Per-bit hardware clear strobes for command bits |
| cmd_q | output | 32 | Current command bits for the controller |
| eof_overrun | input | 1 | Periodic work missed end of frame (one pulse per frame) |
| ovr_flag_clr | input | 1 | Clear strobe for the sticky overrun flag |
| ovr_flag | output | 1 | Sticky overrun status flag |

## Verification
The bench builds two copies from the same stimulus. One uses the default `CLR_WINS` = 0 and the other uses `CLR_WINS` = 1. The same-cycle set/clear collisions therefore show both priority outcomes side by side, and every other requirement is checked on both builds. Both copies keep the default five-bit command mask. This keeps all-ones writes within reach, which probe masked bits, unused bits and the counter field at once. Runs of four and more overrun events take the count through its wrap.

// File: rtl/cmdstat_pkg.sv
package cmdstat_pkg;

    localparam int REG_W = 32;

    typedef logic [REG_W-1:0] reg_word_t;

    // One cycle's worth of requested changes to the command bits.
    typedef struct packed {
        reg_word_t set_bits;
        reg_word_t clr_bits;
    } cmd_upd_t;

    // Overrun tracker state carried as one bundle.
    typedef struct packed {
        logic [1:0] cnt;
        logic       flag;
    } ovr_state_t;

    // Contiguous field mask of width bits starting at lsb.
    function automatic reg_word_t field_mask(input int lsb, input int width);
        reg_word_t m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i >= lsb && i < lsb + width) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Next command word when a set beats a clear on the same bit.
    function automatic reg_word_t upd_set_first(input reg_word_t cur, input cmd_upd_t u);
        return (cur & ~u.clr_bits) | u.set_bits;
    endfunction

    // Next command word when a clear beats a set on the same bit.
    function automatic reg_word_t upd_clr_first(input reg_word_t cur, input cmd_upd_t u);
        return (cur | u.set_bits) & ~u.clr_bits;
    endfunction

endpackage

// File: rtl/cmdstat_cmd_bank.sv
module cmdstat_cmd_bank
    import cmdstat_pkg::*;
#(
    parameter reg_word_t LIVE_MASK = 32'h0000_001F,
    parameter bit        CLR_WINS  = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  cmd_upd_t  upd,
    output reg_word_t cmd_q
);

    reg_word_t cmd_d;

    generate
        if (CLR_WINS) begin : g_clr_first
            always_comb cmd_d = upd_clr_first(cmd_q, upd);
        end else begin : g_set_first
            always_comb cmd_d = upd_set_first(cmd_q, upd);
        end
    endgenerate

    // Positions outside the live mask never leave zero.
    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd_d & LIVE_MASK;
    end

endmodule

// File: rtl/cmdstat_ovr_track.sv
module cmdstat_ovr_track
    import cmdstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       eof_overrun,
    input  logic       flag_clr,
    output ovr_state_t st_q
);

    ovr_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (eof_overrun) begin
            st_d.cnt  = st_q.cnt + 2'd1;
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/cmdstat_rd_path.sv
module cmdstat_rd_path
    import cmdstat_pkg::*;
#(
    parameter int OVR_LSB = 16
) (
    input  logic       hit,
    input  reg_word_t  cmd_q,
    input  logic [1:0] cnt,
    output reg_word_t  rdata
);

    reg_word_t image;

    always_comb begin
        image = cmd_q;
        image[OVR_LSB +: 2] = cnt;
        rdata = hit ? image : '0;
    end

endmodule

// File: rtl/cmd_status_reg.sv
module cmd_status_reg
    import cmdstat_pkg::*;
#(
    parameter logic [31:0] CMD_MASK = 32'h0000_001F,
    parameter int          OVR_LSB  = 16,
    parameter bit          CLR_WINS = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_hit,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] hw_clr,
    output logic [31:0] cmd_q,
    input  logic        eof_overrun,
    input  logic        ovr_flag_clr,
    output logic        ovr_flag
);

    localparam reg_word_t OVR_FIELD = field_mask(OVR_LSB, 2);
    localparam reg_word_t LIVE_MASK = CMD_MASK & ~OVR_FIELD;

    cmd_upd_t   upd;
    ovr_state_t ovr_st;
    logic [1:0] ovr_cnt;
    logic       wr_fire;

    assign wr_fire = reg_hit & reg_wr;

    always_comb begin
        upd.set_bits = wr_fire ? (reg_wdata & LIVE_MASK) : '0;
        upd.clr_bits = hw_clr & LIVE_MASK;
    end

    cmdstat_cmd_bank #(
        .LIVE_MASK (LIVE_MASK),
        .CLR_WINS  (CLR_WINS)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .upd   (upd),
        .cmd_q (cmd_q)
    );

    cmdstat_ovr_track u_ovr (
        .clk         (clk),
        .rst         (rst),
        .eof_overrun (eof_overrun),
        .flag_clr    (ovr_flag_clr),
        .st_q        (ovr_st)
    );

    assign ovr_cnt  = ovr_st.cnt;
    assign ovr_flag = ovr_st.flag;

    cmdstat_rd_path #(
        .OVR_LSB (OVR_LSB)
    ) u_rd (
        .hit   (reg_hit),
        .cmd_q (cmd_q),
        .cnt   (ovr_cnt),
        .rdata (reg_rdata)
    );

endmodule

// File: rtl/cmdstat_chk.sv
module cmdstat_chk #(
    parameter logic [31:0] CMD_MASK = 32'h0000_001F,
    parameter int          OVR_LSB  = 16,
    parameter bit          CLR_WINS = 1'b0
) (
    input logic        clk,
    input logic        rst,
    input logic        reg_hit,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [31:0] hw_clr,
    input logic [31:0] cmd_q,
    input logic        eof_overrun,
    input logic        ovr_flag_clr,
    input logic        ovr_flag,
    input logic [1:0]  ovr_cnt
);

    localparam logic [31:0] FLD  = 32'h3 << OVR_LSB;
    localparam logic [31:0] LIVE = CMD_MASK & ~FLD;

    logic [31:0] sw_set, hw_kill;
    assign sw_set  = (reg_hit && reg_wr) ? (reg_wdata & LIVE) : '0;
    assign hw_kill = hw_clr & LIVE;

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (cmd_q == '0 && !ovr_flag && ovr_cnt == 2'd0));

    // R2
    set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        ((sw_set & ~hw_kill) != '0) |=>
        ((cmd_q & $past(sw_set & ~hw_kill)) == $past(sw_set & ~hw_kill)));

    // R4
    hw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_set == '0 && hw_kill != '0) |=> ((cmd_q & $past(hw_kill)) == '0));

    // R5
    generate
        if (CLR_WINS) begin : g_clr
            collide_clr_chk: assert property (@(posedge clk) disable iff (rst)
                ((sw_set & hw_kill) != '0) |=> ((cmd_q & $past(sw_set & hw_kill)) == '0));
        end else begin : g_set
            collide_set_chk: assert property (@(posedge clk) disable iff (rst)
                ((sw_set & hw_kill) != '0) |=>
                ((cmd_q & $past(sw_set & hw_kill)) == $past(sw_set & hw_kill)));
        end
    endgenerate

    // R6
    ovr_step_chk: assert property (@(posedge clk) disable iff (rst)
        eof_overrun |=> (ovr_cnt == 2'($past(ovr_cnt) + 2'd1)));

    // R7
    ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !eof_overrun |=> $stable(ovr_cnt));

    // R8
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        eof_overrun |=> ovr_flag);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !ovr_flag_clr) |=> ovr_flag);

    // R9
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~(LIVE | FLD)) == '0);

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_hit |-> (reg_rdata == '0));

    // R11
    cmd_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        reg_hit |-> ((reg_rdata & LIVE) == cmd_q));

endmodule

bind cmd_status_reg cmdstat_chk #(
    .CMD_MASK (CMD_MASK),
    .OVR_LSB  (OVR_LSB),
    .CLR_WINS (CLR_WINS)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .reg_hit      (reg_hit),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .hw_clr       (hw_clr),
    .cmd_q        (cmd_q),
    .eof_overrun  (eof_overrun),
    .ovr_flag_clr (ovr_flag_clr),
    .ovr_flag     (ovr_flag),
    .ovr_cnt      (ovr_cnt)
);

// File: tb/cmd_status_reg_tb_top.sv
module cmd_status_reg_tb_top;

    localparam logic [31:0] MASK = 32'h0000_001F;

    typedef struct {
        logic [31:0] rd_a;
        logic [31:0] rd_b;
        logic [31:0] cmd;
        logic        flag;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_hit = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0, hw_clr = '0;
    logic        eof_overrun = 1'b0, ovr_flag_clr = 1'b0;
    logic [31:0] rdata_a, rdata_b, cmd_a, cmd_b;
    logic        flag_a, flag_b;

    int vectors = 0;
    int misses  = 0;
    bit mon_en  = 1'b0;
    bit done    = 1'b0;
    exp_t sb_q[$];

    logic [31:0] m_a = '0, m_b = '0;
    logic [1:0]  m_cnt = '0;
    logic        m_flag = 1'b0;

    always #10 clk = ~clk;

    cmd_status_reg #(.CLR_WINS(1'b0)) dut_i (
        .clk(clk), .rst(rst), .reg_hit(reg_hit), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .hw_clr(hw_clr),
        .cmd_q(cmd_a), .eof_overrun(eof_overrun),
        .ovr_flag_clr(ovr_flag_clr), .ovr_flag(flag_a));

    cmd_status_reg #(.CLR_WINS(1'b1)) dut_clr_i (
        .clk(clk), .rst(rst), .reg_hit(reg_hit), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .hw_clr(hw_clr),
        .cmd_q(cmd_b), .eof_overrun(eof_overrun),
        .ovr_flag_clr(ovr_flag_clr), .ovr_flag(flag_b));

    function automatic logic [31:0] image(input logic [31:0] c, input logic [1:0] n);
        return c | ({30'b0, n} << 16);
    endfunction

    // Driver: one bus cycle; pushes the expected read result when chk is set.
    task automatic step(input logic hit, input logic wr, input logic [31:0] wd,
                        input logic [31:0] clr, input logic eof, input logic fclr,
                        input bit chk, input string req);
        exp_t e;
        logic [31:0] s, c;
        @(posedge clk); #2;
        reg_hit = hit; reg_wr = wr; reg_wdata = wd; hw_clr = clr;
        eof_overrun = eof; ovr_flag_clr = fclr;
        if (chk) begin
            e.rd_a = hit ? image(m_a, m_cnt) : '0;
            e.rd_b = hit ? image(m_b, m_cnt) : '0;
            e.cmd  = m_a;
            e.flag = m_flag;
            e.req  = req;
            sb_q.push_back(e);
        end
        mon_en = chk;
        s = (hit && wr) ? (wd & MASK) : '0;
        c = clr & MASK;
        m_a = (m_a & ~c) | s;
        m_b = (m_b | s) & ~c;
        if (eof) m_cnt = m_cnt + 2'd1;
        m_flag = eof | (m_flag & ~fclr);
    endtask

    task automatic rd(input string req);
        step(1'b1, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, req);
    endtask

    task automatic wr(input logic [31:0] d, input logic [31:0] clr);
        step(1'b1, 1'b1, d, clr, 1'b0, 1'b0, 1'b0, "");
    endtask

    // Monitor: pops and compares at the falling edge.
    always @(negedge clk) begin
        if (mon_en && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            vectors++;
            if (rdata_a !== e.rd_a) begin
                misses++;
                $display("FAIL %s rdata(set-wins) act=%h exp=%h", e.req, rdata_a, e.rd_a);
            end
            if (rdata_b !== e.rd_b) begin
                misses++;
                $display("FAIL %s rdata(clr-wins) act=%h exp=%h", e.req, rdata_b, e.rd_b);
            end
            if (cmd_a !== e.cmd) begin
                misses++;
                $display("FAIL %s cmd_q act=%h exp=%h", e.req, cmd_a, e.cmd);
            end
            if (flag_a !== e.flag || flag_b !== e.flag) begin
                misses++;
                $display("FAIL %s ovr_flag act=%b/%b exp=%b", e.req, flag_a, flag_b, e.flag);
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        rd("R1");                               // reset state
        wr(32'h0000_0001, '0);
        rd("R2");                               // first set
        wr(32'h0000_0004, '0);
        rd("R2");                               // accumulates, 0x05
        wr(32'h0000_0000, '0);
        rd("R2");                               // zeros leave bits alone
        step(1'b0, 1'b1, 32'h1F, '0, 1'b0, 1'b0, 1'b0, "");
        step(1'b1, 1'b0, 32'h1F, '0, 1'b0, 1'b0, 1'b0, "");
        rd("R3");                               // still 0x05
        wr(32'hFFFF_FFFF, '0);
        rd("R9");                               // only 0x1F lands; R7 field untouched
        rd("R11");
        step(1'b0, 1'b0, '0, 32'h0000_0002, 1'b0, 1'b0, 1'b0, "");
        rd("R4");                               // 0x1D
        step(1'b0, 1'b0, '0, 32'hFFFF_FFE0, 1'b0, 1'b0, 1'b0, "");
        rd("R4");                               // non-command clears ignored
        wr(32'h0000_0003, 32'h0000_0003);
        rd("R5");                               // A keeps bits, B drops them
        wr('0, 32'h0000_001F);
        wr(32'h0000_0010, 32'h0000_0011);
        rd("R5");
        step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 1'b0, "");
        rd("R6");                               // count 1, flag set
        rd("R8");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 1'b0, "");
        rd("R6");                               // wrapped to 0
        step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 1'b0, "");
        wr(32'h0003_0000, '0);
        rd("R7");                               // count stays 1
        step(1'b0, 1'b0, '0, '0, 1'b0, 1'b1, 1'b0, "");
        rd("R8");                               // flag cleared
        step(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 1'b0, "");
        rd("R8");                               // set wins over clear
        step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, "R10"); // idle read is 0
        wr(32'h0000_0008, '0);
        rd("R10");                              // visible same cycle as hit
        step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, "");
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule